// File: doc/BRIEF.md
# Bytewide Static Memory with Write-Protect Gating

This block is a clock-sampled model of a 2048-word by 8-bit static memory behind a bytewide bus with active-low select, write strobe and output strobe. All control and address levels are sampled on the rising clock. A read is a purely combinational path from the address to the data outputs while the read levels hold. A write opens when the select and write strobes are both sampled low. It closes when either strobe is sampled high, and the data is committed at that closing edge. After each write, the write strobe must stay high for a programmable number of clocks before another write is accepted.

A protect input comes from an external supply supervisor. While it is high, every control and address input is ignored, any open write is dropped, and the data outputs are released. Protocol misuse sets a sticky error flag, which only reset clears: a write attempt during the recovery window, or an address that moves while a write is open.

The write sequencer has three states. IDLE goes to WRITE when both strobes are sampled low. WRITE goes to RECOVER at the first edge that samples either strobe high, and commits the write unless the address moved. RECOVER goes back to IDLE after REC_CYC consecutive edges that sample the write strobe high. A low write strobe in RECOVER restarts that count. Protect forces any state to IDLE.

Top module: `nvb_sram_top`

## Requirements
- R1: The array stores 2048 words of 8 bits addressed by the 11-bit `addr`. Reset does not clear its contents.
- R2: When `protect`=0, `ce_n`=0, `oe_n`=0 and `we_n`=1, `dout_en`=1 and `dout` shows the word at `addr` in the same cycle. When the outputs are off, `dout_en`=0 and `dout`=0.
- R3: A write opens at the first clock edge in IDLE that samples both `ce_n` and `we_n` low, whichever of them fell last. The address is latched at that edge.
- R4: A write closes at the first edge that samples `ce_n` or `we_n` high. The `din` value sampled at that edge is stored, and earlier `din` values have no effect.
- R5: If the outputs are on when `we_n` is first sampled low, `dout_en` stays 1 through ODIS_CYC edges that sample `we_n` low and drops after the last of them (ODIS_CYC=2 in the bench).
- R6: While `protect`=1, `dout_en`=0, no write opens, and an open write is dropped without storing anything.
- R7: After a write closes, REC_CYC consecutive edges must sample `we_n` high before the next write can open (REC_CYC=3 in the bench). A write attempt sampled earlier is ignored, sets `err`, and restarts the count.
- R8: If `addr` differs from the latched address at any edge of an open write, that write stores nothing and `err` is set.
- R9: `err` stays at 1 until reset. Reset returns the sequencer to IDLE and clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output strobe |
| addr | input | 11 | Word address |
| din | input | 8 | Write data |
| protect | input | 1 | Write protect and output release from the supply supervisor |
| dout | output | 8 | Read data, zero when not driven |
| dout_en | output | 1 | Output driver enable |
| err | output | 1 | Sticky protocol error |

## Verification
Every address is written and read back with a value computed from the address. The sweep rotates through three strobe orderings: close by write strobe, close by select, and select falling after the write strobe. This separates address decoding faults from strobe-framing faults. Directed patterns then apply `din` changes inside an open write, a write strobe falling during a read, writes under protect and protect raised mid-write, a moved address, and a write strobe pulse inside the recovery window. Each directed case checks that the data stored, the output enable and the error flag match only the documented edge.

// File: rtl/nvb_pkg.sv
package nvb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WRITE   = 2'd1,
        ST_RECOVER = 2'd2
    } wr_state_e;
endpackage

// File: rtl/nvb_array.sv
module nvb_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Storage has no reset: contents survive rst_n (R1)
    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_addr] <= wr_data;
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/nvb_cycle_fsm.sv
module nvb_cycle_fsm
    import nvb_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int REC_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              protect,
    input  logic [ADDR_W-1:0] addr,
    output logic              commit,
    output logic [ADDR_W-1:0] commit_addr,
    output logic              err
);
    localparam int CNT_W = (REC_CYC < 2) ? 1 : $clog2(REC_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REC_CYC - 1);

    wr_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [ADDR_W-1:0] wa_q, wa_d;
    logic              bad_q, bad_d;
    logic              err_q, err_set;
    logic              both_low, addr_moved;

    assign both_low   = !ce_n && !we_n;
    assign addr_moved = (addr != wa_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            wa_q    <= '0;
            bad_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            wa_q    <= wa_d;
            bad_q   <= bad_d;
            err_q   <= err_q | err_set;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        wa_d    = wa_q;
        bad_d   = bad_q;
        commit  = 1'b0;
        err_set = 1'b0;
        if (protect) begin
            // R6: inputs ignored, open write dropped
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (both_low) begin
                        state_d = ST_WRITE;
                        wa_d    = addr;
                        bad_d   = 1'b0;
                    end
                end
                ST_WRITE: begin
                    if (addr_moved) err_set = 1'b1;
                    if (ce_n || we_n) begin
                        commit  = !(bad_q || addr_moved);
                        state_d = ST_RECOVER;
                        cnt_d   = '0;
                    end else if (addr_moved) begin
                        bad_d = 1'b1;
                    end
                end
                ST_RECOVER: begin
                    if (!we_n) begin
                        cnt_d = '0;
                        if (!ce_n) err_set = 1'b1;
                    end else if (cnt_q == CNT_LAST) begin
                        state_d = ST_IDLE;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign commit_addr = wa_q;
    assign err         = err_q;

    a_r4_commit_enters_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (state_q == ST_RECOVER));
    a_r7_no_open_from_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECOVER) |=> (state_q != ST_WRITE));
    a_r6_protect_idles: assert property (@(posedge clk) disable iff (!rst_n)
        protect |=> (state_q == ST_IDLE));
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
endmodule

// File: rtl/nvb_out_gate.sv
module nvb_out_gate #(
    parameter int ODIS_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    input  logic protect,
    output logic drv_en
);
    localparam int HW = $clog2(ODIS_CYC + 2);

    logic [HW-1:0] hold_q;
    logic          sel_on;

    assign sel_on = !protect && !ce_n && !oe_n;

    // Hold counter: loaded while the write strobe is high, drained while low (R5)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            hold_q <= '0;
        else if (we_n)         hold_q <= sel_on ? HW'(ODIS_CYC) : '0;
        else if (hold_q != '0) hold_q <= hold_q - HW'(1);
    end

    assign drv_en = sel_on && (we_n || (hold_q != '0));

    a_r6_release_under_protect: assert property (@(posedge clk) disable iff (!rst_n)
        protect |-> !drv_en);
    a_r5_hold_expired: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && hold_q == '0) |-> !drv_en);
endmodule

// File: rtl/nvb_sram_top.sv
module nvb_sram_top #(
    parameter int ADDR_W   = 11,
    parameter int DATA_W   = 8,
    parameter int REC_CYC  = 3,
    parameter int ODIS_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              protect,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              err
);
    logic              commit;
    logic [ADDR_W-1:0] commit_addr;
    logic [DATA_W-1:0] rd_data;

    nvb_cycle_fsm #(.ADDR_W(ADDR_W), .REC_CYC(REC_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .protect(protect),
        .addr(addr), .commit(commit), .commit_addr(commit_addr), .err(err)
    );

    nvb_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .wr_en(commit), .wr_addr(commit_addr), .wr_data(din),
        .rd_addr(addr), .rd_data(rd_data)
    );

    nvb_out_gate #(.ODIS_CYC(ODIS_CYC)) u_gate (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .protect(protect), .drv_en(dout_en)
    );

    assign dout = dout_en ? rd_data : '0;

    a_r2_drive_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (!ce_n && !oe_n && !protect));
endmodule

// File: tb/test_nvb_sram_top.sv
module test_nvb_sram_top;
    localparam int AW = 11;
    localparam int DW = 8;
    localparam int REC = 3;
    localparam int ODIS = 2;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, protect = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en, err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    logic [DW-1:0] model [DEPTH];

    always #10 clk = ~clk;

    nvb_sram_top #(.ADDR_W(AW), .DATA_W(DW), .REC_CYC(REC), .ODIS_CYC(ODIS)) i_nvb_sram_top (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .protect(protect),
        .dout(dout), .dout_en(dout_en), .err(err)
    );

    function automatic logic [DW-1:0] pat(int a);
        return DW'((a * 37 + (a >> 3)) ^ 8'h5A);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // style 0: close by we_n, 1: close by ce_n, 2: ce_n falls after we_n
    task automatic do_write(int a, logic [DW-1:0] d, int style);
        @(negedge clk);
        addr = AW'(a); din = d; oe_n = 1'b1;
        if (style == 2) begin
            we_n = 1'b0; ce_n = 1'b1;
            @(negedge clk);
            ce_n = 1'b0;
        end else begin
            ce_n = 1'b0; we_n = 1'b0;
        end
        @(negedge clk);
        if (style == 1) ce_n = 1'b1; else we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        repeat (REC + 1) @(negedge clk);
    endtask

    task automatic do_read(int a, string req);
        @(negedge clk);
        addr = AW'(a); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #2;
        check(req, 32'(dout_en), 32'd1);
        check(req, 32'(dout), 32'(model[a]));
    endtask

    task automatic idle_bus();
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic pulse_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2;
        check("R9 reset err", 32'(err), 32'd0);
        check("R2 reset dout_en", 32'(dout_en), 32'd0);
        check("R2 reset dout", 32'(dout), 32'd0);
        rst_n = 1'b1;

        // R1 R3 R4: sweep every address, rotating strobe orderings
        for (int a = 0; a < DEPTH; a++) begin
            model[a] = pat(a);
            do_write(a, pat(a), a % 3);
        end
        for (int a = 0; a < DEPTH; a++) do_read(a, "R1 sweep readback");
        check("R9 no err after clean sweep", 32'(err), 32'd0);

        // R2: gating levels
        @(negedge clk); addr = 11'd100; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; #2;
        check("R2 oe_n high off", 32'(dout_en), 32'd0);
        check("R2 dout zero when off", 32'(dout), 32'd0);
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; #2;
        check("R2 ce_n high off", 32'(dout_en), 32'd0);

        // R5: write strobe falls during a read; the write then stores 8'hC3
        do_read(200, "R2 read before hold");
        @(negedge clk); we_n = 1'b0; #2;
        check("R5 hold before first edge", 32'(dout_en), 32'd1);
        @(negedge clk); #2;
        check("R5 hold after first low edge", 32'(dout_en), 32'd1);
        @(negedge clk); #2;
        check("R5 off after second low edge", 32'(dout_en), 32'd0);
        din = 8'hC3; we_n = 1'b1; oe_n = 1'b1;
        model[200] = 8'hC3;
        @(negedge clk); ce_n = 1'b1;
        repeat (REC + 1) @(negedge clk);
        do_read(200, "R5 write during hold stored");

        // R4: only din at the closing edge counts
        idle_bus();
        addr = 11'd11; din = 8'h44; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk); din = 8'h55;
        @(negedge clk); din = 8'h66; we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
        model[11] = 8'h66;
        repeat (REC + 1) @(negedge clk);
        do_read(11, "R4 closing edge data");

        // R6: writes and reads under protect, then a mid-write protect abort
        idle_bus();
        protect = 1'b1;
        do_write(9, 8'h33, 0);
        @(negedge clk); addr = 11'd9; ce_n = 1'b0; oe_n = 1'b0; #2;
        check("R6 outputs off under protect", 32'(dout_en), 32'd0);
        check("R6 dout zero under protect", 32'(dout), 32'd0);
        idle_bus(); protect = 1'b0;
        do_read(9, "R6 protected write ignored");
        idle_bus();
        addr = 11'd10; din = 8'h77; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk); protect = 1'b1;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
        @(negedge clk); protect = 1'b0;
        repeat (REC + 1) @(negedge clk);
        do_read(10, "R6 aborted write stores nothing");
        check("R6 no err from protect", 32'(err), 32'd0);

        // R7: write strobe pulse inside recovery window
        idle_bus();
        addr = 11'd5; din = 8'h11; ce_n = 1'b0; we_n = 1'b0;
        model[5] = 8'h11;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); we_n = 1'b0; din = 8'h99;
        @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
        repeat (REC + 2) @(negedge clk);
        #2;
        check("R7 err on early attempt", 32'(err), 32'd1);
        do_read(5, "R7 early attempt ignored");
        idle_bus(); #2;
        check("R9 err held", 32'(err), 32'd1);
        pulse_reset(); #2;
        check("R9 reset clears err", 32'(err), 32'd0);
        do_read(5, "R1 contents survive reset");

        // R8: address moved during an open write
        idle_bus();
        addr = 11'd7; din = 8'h22; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk); addr = 11'd8;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
        repeat (REC + 1) @(negedge clk);
        #2;
        check("R8 err on moved address", 32'(err), 32'd1);
        do_read(7, "R8 first address untouched");
        do_read(8, "R8 second address untouched");
        pulse_reset();
        do_write(8, 8'hE1, 0);
        model[8] = 8'hE1;
        do_read(8, "R7 write accepted after recovery");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule